// File: doc/BRIEF.md
# Privileged Trap Entry and Return Unit

This block performs the architectural state changes that happen when a core with user, supervisor and machine privilege levels takes a trap or returns from one. A trap request carries a cause code, an interrupt flag, a trap value and the pc of the faulting instruction. Two return strobes request a machine-level or a supervisor-level return. The block decides which level handles each trap by consulting its exception and interrupt delegation registers. It saves pc, cause and trap value at that level, updates the interrupt-enable stack and the privilege, and produces the new pc as a one-cycle redirect.

The privilege register is the state machine. Its three states are `PRV_U` (encoding 0), `PRV_S` (1) and `PRV_M` (3). There are four named transitions: `TAKE_S` (trap routed to supervisor, the state becomes `PRV_S`), `TAKE_M` (trap routed to machine, the state becomes `PRV_M`), `RET_M` (the state becomes the saved machine previous-privilege) and `RET_S` (the state becomes the saved supervisor previous-privilege). When no event is present, the state holds. Software reaches the status fields, the save registers, the vector bases and the delegation masks through a simple select/write port with a combinational read-back.

Top module: `trap_unit`

## Requirements
- R1: After reset the privilege is machine (3), `target_pc_o` is 0x1000, `redirect_o` is 0, and every status field and every save, vector and delegation register reads 0.
- R2: A trap taken in machine mode always goes to machine mode, whatever the delegation registers hold. Traps taken in user or supervisor mode are routed by delegation.
- R3: An interrupt is routed to supervisor when bit `code` of the interrupt delegation register is set. An exception is routed to supervisor when bit `code` of the exception delegation register is set.
- R4: The saved cause word holds the code in its low bits and has bit XLEN-1 set for interrupts and clear for exceptions.
- R5: A supervisor trap writes the trap pc to sepc, the cause word to scause and the trap value to stval. Status bit 5 (SPIE) takes the enable bit indexed by the old privilege, status bit 8 (SPP) takes the old privilege, and status bit 1 (SIE) is cleared. The privilege becomes supervisor and the new pc is the old stvec.
- R6: A machine trap writes mepc, mcause and mtval in the same way. Status bit 7 (MPIE) takes the enable bit of the old privilege, status bits 12:11 (MPP) take the old privilege, and status bit 3 (MIE) is cleared. The privilege becomes machine and the new pc is the old mtvec.
- R7: A machine return loads the enable bit indexed by MPP from MPIE, sets MPIE, clears MPP to user, moves the privilege to the old MPP and redirects to mepc.
- R8: A supervisor return loads the enable bit indexed by SPP from SPIE, sets SPIE, clears SPP, moves the privilege to the old SPP and redirects to sepc.
- R9: Writes to mtvec and stvec clear bits 1:0. Writes to mepc and sepc clear bit 0.
- R10: The exception delegation register keeps only bits 15:0 of a write. Its upper bits always read 0.
- R11: A trap request wins over a same-cycle return strobe, and a machine return wins over a same-cycle supervisor return. A trap's capture of a save register wins over a same-cycle software write to that register.
- R12: The CSR select codes are 0 for status, 1 for mepc, 2 for mcause, 3 for mtval, 4 for mtvec, 5 for exception delegation, 6 for interrupt delegation, 8 for sepc, 9 for scause, 10 for stval and 11 for stvec. Status bits are 0 UIE, 1 SIE, 3 MIE, 5 SPIE, 7 MPIE, 8 SPP and 12:11 MPP. A status write whose MPP field is 2 leaves MPP unchanged. A status write in a cycle with an event is dropped.
- R13: `redirect_o`, `target_pc_o` and `priv_o` change at the clock edge that samples the request. `redirect_o` is high for exactly that one cycle per event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_req | input | 1 | Take a trap this cycle |
| trap_irq | input | 1 | Trap is an interrupt (1) or an exception (0) |
| trap_code | input | CODE_W | Cause code, also the delegation bit index |
| trap_tval | input | XLEN | Trap value to save |
| trap_pc | input | XLEN | pc of the trapping instruction |
| mret_req | input | 1 | Machine-level return strobe |
| sret_req | input | 1 | Supervisor-level return strobe |
| csr_we | input | 1 | Write the register chosen by `csr_sel` |
| csr_sel | input | 4 | Register select for write and read-back |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Combinational read-back of the selected register |
| redirect_o | output | 1 | One-cycle pulse: the pc must jump to `target_pc_o` |
| target_pc_o | output | XLEN | Redirect target, held between events |
| priv_o | output | 2 | Current privilege |

## Verification
Every result of a trap or return lands at the rising edge that samples the request. Privilege, redirect pulse, target pc and all saved registers are therefore due one cycle after the stimulus is applied. `csr_rdata` follows `csr_sel` within the same cycle. The bench changes inputs just after a rising edge and advances its behavioural model on that same edge. It then compares privilege, redirect, target pc and the read-back of the currently selected register against the model on every falling edge. Each result is thus checked in the exact cycle it is due, and also in every cycle it must hold.

// File: rtl/trap_pkg.sv
package trap_pkg;

    typedef enum logic [1:0] {
        PRV_U = 2'b00,
        PRV_S = 2'b01,
        PRV_M = 2'b11
    } priv_e;

    typedef enum logic [1:0] {
        EV_NONE = 2'b00,
        EV_TRAP = 2'b01,
        EV_MRET = 2'b10,
        EV_SRET = 2'b11
    } event_e;

    typedef struct packed {
        logic       uie;
        logic       sie;
        logic       mie;
        logic       spie;
        logic       mpie;
        logic       spp;
        logic [1:0] mpp;
    } status_wr_t;

    localparam logic [3:0] SEL_STATUS  = 4'h0;
    localparam logic [3:0] SEL_MEPC    = 4'h1;
    localparam logic [3:0] SEL_MCAUSE  = 4'h2;
    localparam logic [3:0] SEL_MTVAL   = 4'h3;
    localparam logic [3:0] SEL_MTVEC   = 4'h4;
    localparam logic [3:0] SEL_EXC_DLG = 4'h5;
    localparam logic [3:0] SEL_IRQ_DLG = 4'h6;
    localparam logic [3:0] SEL_SEPC    = 4'h8;
    localparam logic [3:0] SEL_SCAUSE  = 4'h9;
    localparam logic [3:0] SEL_STVAL   = 4'hA;
    localparam logic [3:0] SEL_STVEC   = 4'hB;

    localparam int ST_UIE  = 0;
    localparam int ST_SIE  = 1;
    localparam int ST_MIE  = 3;
    localparam int ST_SPIE = 5;
    localparam int ST_MPIE = 7;
    localparam int ST_SPP  = 8;
    localparam int ST_MPP  = 11;

endpackage

// File: rtl/trap_deleg.sv
module trap_deleg
    import trap_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int CODE_W = 5
) (
    input  priv_e             priv,
    input  logic              is_irq,
    input  logic [CODE_W-1:0] code,
    input  logic [XLEN-1:0]   exc_dlg,
    input  logic [XLEN-1:0]   irq_dlg,
    output logic              to_s
);

    // Routing: machine-mode traps never leave machine mode.
    always_comb begin
        to_s = 1'b0;
        if (priv != PRV_M) begin
            to_s = is_irq ? irq_dlg[code] : exc_dlg[code];
        end
    end

endmodule

// File: rtl/trap_status_fsm.sv
module trap_status_fsm
    import trap_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  event_e          ev,
    input  logic            to_s,
    input  logic            st_we,
    input  status_wr_t      st_wr,
    output priv_e           priv_q,
    output logic [XLEN-1:0] status_o
);

    priv_e      priv_d;
    logic [3:0] ie_q, ie_d;
    logic       spie_q, spie_d;
    logic       mpie_q, mpie_d;
    logic       spp_q, spp_d;
    logic [1:0] mpp_q, mpp_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            priv_q <= PRV_M;
            ie_q   <= '0;
            spie_q <= 1'b0;
            mpie_q <= 1'b0;
            spp_q  <= 1'b0;
            mpp_q  <= 2'b00;
        end else begin
            priv_q <= priv_d;
            ie_q   <= ie_d;
            spie_q <= spie_d;
            mpie_q <= mpie_d;
            spp_q  <= spp_d;
            mpp_q  <= mpp_d;
        end
    end

    // Transitions: TAKE_S, TAKE_M, RET_M, RET_S, or hold
    always_comb begin
        priv_d = priv_q;
        ie_d   = ie_q;
        spie_d = spie_q;
        mpie_d = mpie_q;
        spp_d  = spp_q;
        mpp_d  = mpp_q;
        unique case (ev)
            EV_TRAP: begin
                if (to_s) begin
                    spie_d = ie_q[priv_q];
                    spp_d  = priv_q[0];
                    ie_d[ST_SIE] = 1'b0;
                    priv_d = PRV_S;
                end else begin
                    mpie_d = ie_q[priv_q];
                    mpp_d  = priv_q;
                    ie_d[ST_MIE] = 1'b0;
                    priv_d = PRV_M;
                end
            end
            EV_MRET: begin
                ie_d[mpp_q] = mpie_q;
                mpie_d = 1'b1;
                mpp_d  = PRV_U;
                priv_d = priv_e'(mpp_q);
            end
            EV_SRET: begin
                ie_d[{1'b0, spp_q}] = spie_q;
                spie_d = 1'b1;
                spp_d  = 1'b0;
                priv_d = spp_q ? PRV_S : PRV_U;
            end
            EV_NONE: begin
                if (st_we) begin
                    ie_d[ST_UIE] = st_wr.uie;
                    ie_d[ST_SIE] = st_wr.sie;
                    ie_d[ST_MIE] = st_wr.mie;
                    spie_d = st_wr.spie;
                    mpie_d = st_wr.mpie;
                    spp_d  = st_wr.spp;
                    if (st_wr.mpp != 2'b10) begin
                        mpp_d = st_wr.mpp;
                    end
                end
            end
        endcase
        ie_d[2] = 1'b0;
    end

    // Outputs
    always_comb begin
        status_o = '0;
        status_o[ST_UIE]  = ie_q[ST_UIE];
        status_o[ST_SIE]  = ie_q[ST_SIE];
        status_o[ST_MIE]  = ie_q[ST_MIE];
        status_o[ST_SPIE] = spie_q;
        status_o[ST_MPIE] = mpie_q;
        status_o[ST_SPP]  = spp_q;
        status_o[ST_MPP+1:ST_MPP] = mpp_q;
    end

    // R5
    take_s_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_TRAP && to_s) |=> (priv_q == PRV_S && !ie_q[ST_SIE]));

    // R6
    take_m_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_TRAP && !to_s) |=> (priv_q == PRV_M && !ie_q[ST_MIE] && mpp_q == $past(priv_q)));

    // R7
    ret_m_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_MRET) |=> (priv_q == priv_e'($past(mpp_q)) && mpp_q == 2'b00 && mpie_q));

    // R8
    ret_s_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_SRET) |=> (!spp_q && spie_q && priv_q[0] == $past(spp_q)));

    // R12
    mpp_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mpp_q != 2'b10);

endmodule

// File: rtl/trap_csr_file.sv
module trap_csr_file
    import trap_pkg::*;
#(
    parameter int XLEN         = 32,
    parameter int CODE_W       = 5,
    parameter int EXC_DLG_BITS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_we,
    input  logic [3:0]        csr_sel,
    input  logic [XLEN-1:0]   csr_wdata,
    input  logic              take_s,
    input  logic              take_m,
    input  logic              is_irq,
    input  logic [CODE_W-1:0] code,
    input  logic [XLEN-1:0]   tval,
    input  logic [XLEN-1:0]   epc_in,
    input  logic [XLEN-1:0]   status_i,
    output logic [XLEN-1:0]   mepc_o,
    output logic [XLEN-1:0]   sepc_o,
    output logic [XLEN-1:0]   mtvec_o,
    output logic [XLEN-1:0]   stvec_o,
    output logic [XLEN-1:0]   exc_dlg_o,
    output logic [XLEN-1:0]   irq_dlg_o,
    output logic [XLEN-1:0]   rdata_o
);

    localparam logic [XLEN-1:0] EXC_MASK  = {{(XLEN-EXC_DLG_BITS){1'b0}}, {EXC_DLG_BITS{1'b1}}};
    localparam logic [XLEN-1:0] TVEC_MASK = {{(XLEN-2){1'b1}}, 2'b00};
    localparam logic [XLEN-1:0] EPC_MASK  = {{(XLEN-1){1'b1}}, 1'b0};

    logic [XLEN-1:0] mepc_q, mcause_q, mtval_q, mtvec_q;
    logic [XLEN-1:0] sepc_q, scause_q, stval_q, stvec_q;
    logic [XLEN-1:0] exc_dlg_q, irq_dlg_q;
    logic [XLEN-1:0] cause_w;

    assign cause_w = {is_irq, {(XLEN-1-CODE_W){1'b0}}, code};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mepc_q    <= '0;
            mcause_q  <= '0;
            mtval_q   <= '0;
            mtvec_q   <= '0;
            sepc_q    <= '0;
            scause_q  <= '0;
            stval_q   <= '0;
            stvec_q   <= '0;
            exc_dlg_q <= '0;
            irq_dlg_q <= '0;
        end else begin
            if (csr_we) begin
                case (csr_sel)
                    SEL_MEPC:    mepc_q    <= csr_wdata & EPC_MASK;
                    SEL_MCAUSE:  mcause_q  <= csr_wdata;
                    SEL_MTVAL:   mtval_q   <= csr_wdata;
                    SEL_MTVEC:   mtvec_q   <= csr_wdata & TVEC_MASK;
                    SEL_EXC_DLG: exc_dlg_q <= csr_wdata & EXC_MASK;
                    SEL_IRQ_DLG: irq_dlg_q <= csr_wdata;
                    SEL_SEPC:    sepc_q    <= csr_wdata & EPC_MASK;
                    SEL_SCAUSE:  scause_q  <= csr_wdata;
                    SEL_STVAL:   stval_q   <= csr_wdata;
                    SEL_STVEC:   stvec_q   <= csr_wdata & TVEC_MASK;
                    default: ;
                endcase
            end
            // trap capture overrides a same-cycle software write
            if (take_m) begin
                mepc_q   <= epc_in;
                mcause_q <= cause_w;
                mtval_q  <= tval;
            end
            if (take_s) begin
                sepc_q   <= epc_in;
                scause_q <= cause_w;
                stval_q  <= tval;
            end
        end
    end

    always_comb begin
        case (csr_sel)
            SEL_STATUS:  rdata_o = status_i;
            SEL_MEPC:    rdata_o = mepc_q;
            SEL_MCAUSE:  rdata_o = mcause_q;
            SEL_MTVAL:   rdata_o = mtval_q;
            SEL_MTVEC:   rdata_o = mtvec_q;
            SEL_EXC_DLG: rdata_o = exc_dlg_q;
            SEL_IRQ_DLG: rdata_o = irq_dlg_q;
            SEL_SEPC:    rdata_o = sepc_q;
            SEL_SCAUSE:  rdata_o = scause_q;
            SEL_STVAL:   rdata_o = stval_q;
            SEL_STVEC:   rdata_o = stvec_q;
            default:     rdata_o = '0;
        endcase
    end

    assign mepc_o    = mepc_q;
    assign sepc_o    = sepc_q;
    assign mtvec_o   = mtvec_q;
    assign stvec_o   = stvec_q;
    assign exc_dlg_o = exc_dlg_q;
    assign irq_dlg_o = irq_dlg_q;

    // R4
    mcause_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_m |=> (mcause_q[XLEN-1] == $past(is_irq) && mepc_q == $past(epc_in)));

    // R4
    scause_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_s |=> (scause_q[XLEN-1] == $past(is_irq) && sepc_q == $past(epc_in)));

    // R9
    tvec_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mtvec_q[1:0] == 2'b00 && stvec_q[1:0] == 2'b00));

    // R10
    exc_dlg_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_dlg_q & ~EXC_MASK) == '0);

endmodule

// File: rtl/trap_unit.sv
module trap_unit
    import trap_pkg::*;
#(
    parameter int              XLEN         = 32,
    parameter logic [XLEN-1:0] RESET_PC     = 'h1000,
    parameter int              EXC_DLG_BITS = 16,
    localparam int             CODE_W       = $clog2(XLEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trap_req,
    input  logic              trap_irq,
    input  logic [CODE_W-1:0] trap_code,
    input  logic [XLEN-1:0]   trap_tval,
    input  logic [XLEN-1:0]   trap_pc,
    input  logic              mret_req,
    input  logic              sret_req,
    input  logic              csr_we,
    input  logic [3:0]        csr_sel,
    input  logic [XLEN-1:0]   csr_wdata,
    output logic [XLEN-1:0]   csr_rdata,
    output logic              redirect_o,
    output logic [XLEN-1:0]   target_pc_o,
    output logic [1:0]        priv_o
);

    event_e          ev;
    priv_e           priv_q;
    logic            to_s;
    logic            st_we;
    status_wr_t      st_wr;
    logic [XLEN-1:0] status_w;
    logic [XLEN-1:0] mepc_w, sepc_w, mtvec_w, stvec_w, exc_dlg_w, irq_dlg_w;
    logic [XLEN-1:0] pc_q;
    logic            redir_q;

    // Event arbitration: trap, then machine return, then supervisor return
    always_comb begin
        if (trap_req)      ev = EV_TRAP;
        else if (mret_req) ev = EV_MRET;
        else if (sret_req) ev = EV_SRET;
        else               ev = EV_NONE;
    end

    assign st_we      = csr_we && (csr_sel == SEL_STATUS);
    assign st_wr.uie  = csr_wdata[ST_UIE];
    assign st_wr.sie  = csr_wdata[ST_SIE];
    assign st_wr.mie  = csr_wdata[ST_MIE];
    assign st_wr.spie = csr_wdata[ST_SPIE];
    assign st_wr.mpie = csr_wdata[ST_MPIE];
    assign st_wr.spp  = csr_wdata[ST_SPP];
    assign st_wr.mpp  = csr_wdata[ST_MPP+1:ST_MPP];

    trap_deleg #(.XLEN(XLEN), .CODE_W(CODE_W)) deleg_i (
        .priv    (priv_q),
        .is_irq  (trap_irq),
        .code    (trap_code),
        .exc_dlg (exc_dlg_w),
        .irq_dlg (irq_dlg_w),
        .to_s    (to_s)
    );

    trap_status_fsm #(.XLEN(XLEN)) fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev       (ev),
        .to_s     (to_s),
        .st_we    (st_we),
        .st_wr    (st_wr),
        .priv_q   (priv_q),
        .status_o (status_w)
    );

    trap_csr_file #(.XLEN(XLEN), .CODE_W(CODE_W), .EXC_DLG_BITS(EXC_DLG_BITS)) csr_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .csr_we    (csr_we),
        .csr_sel   (csr_sel),
        .csr_wdata (csr_wdata),
        .take_s    (ev == EV_TRAP && to_s),
        .take_m    (ev == EV_TRAP && !to_s),
        .is_irq    (trap_irq),
        .code      (trap_code),
        .tval      (trap_tval),
        .epc_in    (trap_pc),
        .status_i  (status_w),
        .mepc_o    (mepc_w),
        .sepc_o    (sepc_w),
        .mtvec_o   (mtvec_w),
        .stvec_o   (stvec_w),
        .exc_dlg_o (exc_dlg_w),
        .irq_dlg_o (irq_dlg_w),
        .rdata_o   (csr_rdata)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q    <= RESET_PC;
            redir_q <= 1'b0;
        end else begin
            redir_q <= (ev != EV_NONE);
            unique case (ev)
                EV_TRAP: pc_q <= to_s ? stvec_w : mtvec_w;
                EV_MRET: pc_q <= mepc_w;
                EV_SRET: pc_q <= sepc_w;
                EV_NONE: pc_q <= pc_q;
            endcase
        end
    end

    assign redirect_o  = redir_q;
    assign target_pc_o = pc_q;
    assign priv_o      = priv_q;

    // R2
    m_never_deleg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && priv_q == PRV_M) |=> (priv_o == 2'b11));

    // R11
    trap_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> (target_pc_o == ($past(to_s) ? $past(stvec_w) : $past(mtvec_w))));

    // R13
    redirect_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req || mret_req || sret_req) |=> redirect_o);

    // R13
    redirect_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(trap_req || mret_req || sret_req) |=> (!redirect_o && $stable(target_pc_o)));

endmodule

// File: tb/trap_unit_tb_top.sv
`timescale 1ns/1ps
module trap_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trap_req = 1'b0, trap_irq = 1'b0;
    logic [4:0]  trap_code = '0;
    logic [31:0] trap_tval = '0, trap_pc = '0;
    logic        mret_req = 1'b0, sret_req = 1'b0;
    logic        csr_we = 1'b0;
    logic [3:0]  csr_sel = '0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        redirect_o;
    logic [31:0] target_pc_o;
    logic [1:0]  priv_o;

    trap_unit dut_i (
        .clk(clk), .rst_n(rst_n),
        .trap_req(trap_req), .trap_irq(trap_irq), .trap_code(trap_code),
        .trap_tval(trap_tval), .trap_pc(trap_pc),
        .mret_req(mret_req), .sret_req(sret_req),
        .csr_we(csr_we), .csr_sel(csr_sel), .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata), .redirect_o(redirect_o),
        .target_pc_o(target_pc_o), .priv_o(priv_o)
    );

    always #2 clk = ~clk;

    int    n_chk = 0;
    int    n_fail = 0;
    int    cyc = 0;
    bit    done = 0;
    string tag = "R1";

    // reference model state
    logic [1:0]  m_priv;
    logic [3:0]  m_ie;
    logic        m_spie, m_mpie, m_spp, m_redir;
    logic [1:0]  m_mpp;
    logic [31:0] m_pc;
    logic [31:0] m_mepc, m_mcause, m_mtval, m_mtvec;
    logic [31:0] m_sepc, m_scause, m_stval, m_stvec;
    logic [31:0] m_medeleg, m_mideleg;

    function automatic logic [31:0] m_status();
        logic [31:0] s = '0;
        s[0] = m_ie[0]; s[1] = m_ie[1]; s[3] = m_ie[3];
        s[5] = m_spie; s[7] = m_mpie; s[8] = m_spp; s[12:11] = m_mpp;
        return s;
    endfunction

    function automatic logic [31:0] m_read(input logic [3:0] s);
        case (s)
            4'h0: return m_status();
            4'h1: return m_mepc;
            4'h2: return m_mcause;
            4'h3: return m_mtval;
            4'h4: return m_mtvec;
            4'h5: return m_medeleg;
            4'h6: return m_mideleg;
            4'h8: return m_sepc;
            4'h9: return m_scause;
            4'hA: return m_stval;
            4'hB: return m_stvec;
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin : model
        logic        ts;
        logic        any_ev;
        logic [31:0] o_mtvec, o_stvec, o_mepc, o_sepc, cw;
        if (!rst_n) begin
            m_priv = 2'b11; m_ie = '0; m_spie = 0; m_mpie = 0; m_spp = 0; m_mpp = 0;
            m_pc = 32'h1000; m_redir = 0;
            m_mepc = 0; m_mcause = 0; m_mtval = 0; m_mtvec = 0;
            m_sepc = 0; m_scause = 0; m_stval = 0; m_stvec = 0;
            m_medeleg = 0; m_mideleg = 0;
        end else begin
            o_mtvec = m_mtvec; o_stvec = m_stvec; o_mepc = m_mepc; o_sepc = m_sepc;
            ts = (m_priv != 2'b11) &&
                 (trap_irq ? m_mideleg[trap_code] : m_medeleg[trap_code]);
            any_ev = trap_req || mret_req || sret_req;
            if (csr_we) begin
                case (csr_sel)
                    4'h0: if (!any_ev) begin
                        m_ie[0] = csr_wdata[0]; m_ie[1] = csr_wdata[1]; m_ie[3] = csr_wdata[3];
                        m_spie = csr_wdata[5]; m_mpie = csr_wdata[7]; m_spp = csr_wdata[8];
                        if (csr_wdata[12:11] != 2'b10) m_mpp = csr_wdata[12:11];
                    end
                    4'h1: m_mepc = csr_wdata & ~32'h1;
                    4'h2: m_mcause = csr_wdata;
                    4'h3: m_mtval = csr_wdata;
                    4'h4: m_mtvec = csr_wdata & ~32'h3;
                    4'h5: m_medeleg = csr_wdata & 32'h0000_FFFF;
                    4'h6: m_mideleg = csr_wdata;
                    4'h8: m_sepc = csr_wdata & ~32'h1;
                    4'h9: m_scause = csr_wdata;
                    4'hA: m_stval = csr_wdata;
                    4'hB: m_stvec = csr_wdata & ~32'h3;
                    default: ;
                endcase
            end
            if (trap_req) begin
                cw = {trap_irq, 26'b0, trap_code};
                if (ts) begin
                    m_scause = cw; m_sepc = trap_pc; m_stval = trap_tval;
                    m_spie = m_ie[m_priv]; m_spp = m_priv[0]; m_ie[1] = 0;
                    m_priv = 2'b01; m_pc = o_stvec;
                end else begin
                    m_mcause = cw; m_mepc = trap_pc; m_mtval = trap_tval;
                    m_mpie = m_ie[m_priv]; m_mpp = m_priv; m_ie[3] = 0;
                    m_priv = 2'b11; m_pc = o_mtvec;
                end
            end else if (mret_req) begin
                m_ie[m_mpp] = m_mpie; m_mpie = 1; m_priv = m_mpp; m_mpp = 0; m_pc = o_mepc;
            end else if (sret_req) begin
                m_ie[{1'b0, m_spp}] = m_spie; m_spie = 1; m_priv = {1'b0, m_spp};
                m_spp = 0; m_pc = o_sepc;
            end
            m_redir = any_ev;
        end
    end

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("priv_o", {30'b0, priv_o}, {30'b0, m_priv});
            chk("redirect_o", {31'b0, redirect_o}, {31'b0, m_redir});
            chk("target_pc_o", target_pc_o, m_pc);
            chk("csr_rdata", csr_rdata, m_read(csr_sel));
        end
    end

    task automatic pulse(input logic tr, input logic irq, input logic [4:0] code,
                         input logic [31:0] tv, input logic [31:0] pc,
                         input logic mr, input logic sr, input logic we,
                         input logic [3:0] sel, input logic [31:0] wd);
        @(posedge clk); #1;
        trap_req = tr; trap_irq = irq; trap_code = code; trap_tval = tv; trap_pc = pc;
        mret_req = mr; sret_req = sr; csr_we = we; csr_sel = sel; csr_wdata = wd;
        @(posedge clk); #1;
        trap_req = 0; trap_irq = 0; trap_code = 0; trap_tval = 0; trap_pc = 0;
        mret_req = 0; sret_req = 0; csr_we = 0; csr_wdata = 0;
    endtask

    task automatic wr(input logic [3:0] sel, input logic [31:0] wd);
        pulse(0, 0, 5'd0, 0, 0, 0, 0, 1, sel, wd);
    endtask

    task automatic rd(input logic [3:0] sel);
        @(posedge clk); #1; csr_sel = sel;
        @(posedge clk); #1;
    endtask

    task automatic trp(input logic irq, input logic [4:0] code, input logic [31:0] tv,
                       input logic [31:0] pc, input logic [3:0] sel);
        pulse(1, irq, code, tv, pc, 0, 0, 0, sel, 0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000 && !done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL R13 watchdog: actual %0d cycles expected under 5000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset values
        tag = "R1";
        rd(4'h0); rd(4'h5); rd(4'h2);
        // R9: alignment masks on vector and epc writes
        tag = "R9";
        wr(4'h4, 32'h0000_2003); rd(4'h4);
        wr(4'hB, 32'h0000_3002); rd(4'hB);
        wr(4'h1, 32'h0000_4001); rd(4'h1);
        wr(4'h8, 32'h0000_5003); rd(4'h8);
        // R10: exception delegation width
        tag = "R10";
        wr(4'h5, 32'hFFFF_FFFF); rd(4'h5);
        wr(4'h6, 32'h0000_0020); rd(4'h6);
        // R12: status layout; MPP value 2 ignored
        tag = "R12";
        wr(4'h0, 32'h0000_0088); rd(4'h0);
        wr(4'h0, 32'h0000_1088); rd(4'h0);
        // R2 / R6: machine-mode trap stays in machine mode despite delegation
        tag = "R2";
        trp(0, 5'd2, 32'hDEAD_0002, 32'h0000_0100, 4'h2);
        tag = "R6";
        rd(4'h1); rd(4'h3); rd(4'h0);
        // R7: return to supervisor
        tag = "R7";
        wr(4'h0, 32'h0000_0880);
        pulse(0, 0, 5'd0, 0, 0, 1, 0, 0, 4'h0, 0);
        rd(4'h0);
        // R5: delegated exception from supervisor
        tag = "R5";
        trp(0, 5'd8, 32'h0000_0BAD, 32'h0000_0204, 4'h9);
        rd(4'h8); rd(4'hA); rd(4'h0);
        // R3 / R4: interrupt delegated by interrupt mask, cause MSB set
        tag = "R4";
        trp(1, 5'd5, 32'h0, 32'h0000_0300, 4'h9);
        tag = "R3";
        trp(1, 5'd2, 32'h0, 32'h0000_0304, 4'h2);
        rd(4'h0);
        tag = "R7";
        pulse(0, 0, 5'd0, 0, 0, 1, 0, 0, 4'h0, 0);
        // R8: supervisor returns, to supervisor then to user
        tag = "R8";
        pulse(0, 0, 5'd0, 0, 0, 0, 1, 0, 4'h0, 0);
        pulse(0, 0, 5'd0, 0, 0, 0, 1, 0, 4'h0, 0);
        rd(4'h0);
        // R2: delegation from user
        tag = "R2";
        trp(0, 5'd8, 32'h0000_0077, 32'h0000_0408, 4'h0);
        // R11: priorities
        tag = "R11";
        pulse(1, 0, 5'd3, 32'h33, 32'h0000_0500, 1, 1, 1, 4'h2, 32'h1234_5678);
        rd(4'h2);
        pulse(0, 0, 5'd0, 0, 0, 1, 1, 0, 4'h0, 0);
        pulse(1, 0, 5'd9, 32'h0, 32'h0000_0600, 0, 0, 1, 4'h0, 32'h0000_0002);
        rd(4'h0);
        // R13: idle cycles hold outputs
        tag = "R13";
        repeat (4) @(posedge clk);
        @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule